// File: doc/BRIEF.md
# Dual Data Pointer Controller

This block holds two 24-bit external-memory pointers for a microcontroller core, a main one and a shadow one, each built from a page byte, a high byte and a low byte. One control byte chooses which pointer drives the address output. It also gives each pointer its own automatic update to apply once an external data access completes, and it can make the block swap to the other pointer after every access.

The core reaches the control byte and the active pointer's three bytes through a small register port. It pulses `acc_done` when an external data transfer that used the pointer has finished. It pulses `ptr_inc` to advance the pointer by one. `ptr_addr` always shows the active pointer. There is no data stream through this block, so every pin is a plain strobe or level and nothing waits on back-pressure. A strobe is acted on in the cycle it is high.

Top module: `dptr_pair_ctrl`

## Requirements
- R1: After reset both pointers are zero, the main pointer is active, both update modes are 0 (no change), auto-swap is off, `ptr_addr` is 0 and the control byte reads 0x00.
- R2: Control bit 0 picks the active pointer: 0 selects main and 1 selects shadow. `ptr_addr` always equals the full 24-bit value of the active pointer.
- R3: A write to register address 1, 2 or 3 loads the low, high or page byte of the active pointer only. A read of the same address returns that byte of the active pointer.
- R4: A `ptr_inc` pulse adds one to all 24 bits of the active pointer, so 0xFFFFFF becomes 0x000000.
- R5: An `acc_done` pulse applies the used pointer's mode to that pointer. Code 0 leaves it as it is. Code 1 adds one and code 2 subtracts one, both modulo 2^24. Code 3 inverts bit 0 only. The other pointer does not change.
- R6: When control bit 6 (auto-swap) is 1, every `acc_done` inverts the select bit after the mode update. When bit 6 is 0, the select bit is kept.
- R7: Control bits 1 and 7 always read 0 and ignore writes. So reading the control byte, adding one and writing it back inverts the select bit. Register addresses 4 to 7 read 0 and ignore writes.
- R8: When `ptr_inc` and `acc_done` are high in the same cycle, the increment is applied first. The mode update then acts on the incremented value, and the auto-swap comes last.
- R9: A cycle with `reg_wr` high performs the write and drops any `acc_done` or `ptr_inc` in that cycle.
- R10: Control bits [3:2] hold the main pointer's mode and bits [5:4] hold the shadow pointer's mode. Both fields load on a control write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 low, 2 high, 3 page |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| acc_done | input | 1 | External data access finished; apply mode and optional swap |
| ptr_inc | input | 1 | Increment the active pointer by one |
| ptr_addr | output | 24 | Active pointer value |

## Verification
Two pairs of functions can land in the same clock. The first pair is the increment command with the post-access update, where an increment plus a post-increment must advance the pointer by two and an increment plus a post-decrement must leave it unchanged. The second pair is a register write with either strobe, where the write must take effect and the strobe must vanish. Directed cycles raise these strobes together under each mode and with auto-swap on and off. A long random stream then overlaps them freely. A behavioural model in the bench predicts `ptr_addr` and the read data every clock and judges the outcome.

// File: rtl/dptr_pkg.sv
package dptr_pkg;
  typedef enum logic [1:0] {
    PM_HOLD = 2'd0,
    PM_INC  = 2'd1,
    PM_DEC  = 2'd2,
    PM_FLIP = 2'd3
  } ptr_mode_e;

  localparam int CTL_SEL_BIT   = 0;
  localparam int CTL_SPARE_BIT = 1;
  localparam int CTL_MODE0_LSB = 2;
  localparam int CTL_MODE1_LSB = 4;
  localparam int CTL_AUTO_BIT  = 6;
  localparam logic [7:0] CTL_WMASK = 8'h7D;
endpackage

// File: rtl/dptr_next.sv
module dptr_next
  import dptr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic              do_inc,
  input  logic              do_acc,
  input  ptr_mode_e         mode,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] stage1;

  always_comb begin
    stage1 = do_inc ? cur + ADDR_W'(1) : cur;
    nxt    = stage1;
    if (do_acc) begin
      unique case (mode)
        PM_INC:  nxt = stage1 + ADDR_W'(1);
        PM_DEC:  nxt = stage1 - ADDR_W'(1);
        PM_FLIP: nxt = {stage1[ADDR_W-1:1], ~stage1[0]};
        default: nxt = stage1;
      endcase
    end
  end
endmodule

// File: rtl/dptr_bank.sv
module dptr_bank #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  localparam int NB = ADDR_W / BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     byte_we,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_val,
  output logic [ADDR_W-1:0] q
);
  for (genvar k = 0; k < NB; k++) begin : g_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[k*BYTE_W +: BYTE_W] <= '0;
      else if (byte_we[k]) q[k*BYTE_W +: BYTE_W] <= wbyte;
      else if (upd_en)     q[k*BYTE_W +: BYTE_W] <= upd_val[k*BYTE_W +: BYTE_W];
    end
  end

  // R5: a pointer that is neither written nor updated keeps its value
  p_untouched_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we == '0 && !upd_en) |=> $stable(q));
endmodule

// File: rtl/dptr_ctrl.sv
module dptr_ctrl
  import dptr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       acc_go,
  output logic       sel,
  output ptr_mode_e  mode_main,
  output ptr_mode_e  mode_shadow,
  output logic [7:0] ctrl_byte
);
  logic [7:0] ctrl_q;
  logic       auto_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl_q <= '0;
    else if (wr_en)  ctrl_q <= wdata & CTL_WMASK;
    else if (acc_go && ctrl_q[CTL_AUTO_BIT])
      ctrl_q[CTL_SEL_BIT] <= ~ctrl_q[CTL_SEL_BIT];
  end

  assign sel         = ctrl_q[CTL_SEL_BIT];
  assign auto_sw     = ctrl_q[CTL_AUTO_BIT];
  assign mode_main   = ptr_mode_e'(ctrl_q[CTL_MODE0_LSB +: 2]);
  assign mode_shadow = ptr_mode_e'(ctrl_q[CTL_MODE1_LSB +: 2]);
  assign ctrl_byte   = ctrl_q;

  // R6: auto-swap inverts the select bit on each access
  p_auto_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && acc_go && auto_sw) |=> sel != $past(sel));
  // R6: without auto-swap the select bit holds
  p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(acc_go && auto_sw)) |=> $stable(sel));
  // R10: mode fields load from a control write
  p_mode_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_main == ptr_mode_e'($past(wdata[3:2]))) &&
              (mode_shadow == ptr_mode_e'($past(wdata[5:4]))));
  // R7: the spare bit never reads back as 1
  p_spare_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !ctrl_byte[CTL_SPARE_BIT]);
endmodule

// File: rtl/dptr_pair_ctrl.sv
module dptr_pair_ctrl
  import dptr_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int BYTE_W  = 8,
  parameter int RA_W    = 3,
  parameter int CTL_OFS = 0,
  parameter int PTR_OFS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              acc_done,
  input  logic              ptr_inc,
  output logic [ADDR_W-1:0] ptr_addr
);
  localparam int NB   = ADDR_W / BYTE_W;
  localparam int NPTR = 2;

  logic              sel;
  ptr_mode_e         mode_main, mode_shadow;
  logic [7:0]        ctrl_byte;
  logic              wr_ctrl, upd_go;
  logic [ADDR_W-1:0] ptr_q [NPTR];

  assign wr_ctrl = reg_wr && (reg_addr == RA_W'(CTL_OFS));
  assign upd_go  = !reg_wr;

  dptr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_ctrl),
    .wdata      (reg_wdata),
    .acc_go     (upd_go && acc_done),
    .sel        (sel),
    .mode_main  (mode_main),
    .mode_shadow(mode_shadow),
    .ctrl_byte  (ctrl_byte)
  );

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    logic              is_act;
    logic              do_inc, do_acc;
    logic [NB-1:0]     bwe;
    logic [ADDR_W-1:0] nxt;
    ptr_mode_e         md;

    assign is_act = (sel == 1'(i));
    assign md     = (i == 0) ? mode_main : mode_shadow;
    assign do_inc = upd_go && ptr_inc && is_act;
    assign do_acc = upd_go && acc_done && is_act;

    for (genvar k = 0; k < NB; k++) begin : g_we
      assign bwe[k] = reg_wr && is_act && (reg_addr == RA_W'(PTR_OFS + k));
    end

    dptr_next #(.ADDR_W(ADDR_W)) u_next (
      .cur   (ptr_q[i]),
      .do_inc(do_inc),
      .do_acc(do_acc),
      .mode  (md),
      .nxt   (nxt)
    );

    dptr_bank #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .byte_we(bwe),
      .wbyte  (reg_wdata),
      .upd_en (do_inc || do_acc),
      .upd_val(nxt),
      .q      (ptr_q[i])
    );
  end

  assign ptr_addr = ptr_q[sel];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == RA_W'(CTL_OFS)) reg_rdata = BYTE_W'(ctrl_byte);
    for (int k = 0; k < NB; k++)
      if (reg_addr == RA_W'(PTR_OFS + k)) reg_rdata = ptr_addr[k*BYTE_W +: BYTE_W];
  end

  // R4: a lone increment advances the output by one, wrapping
  p_inc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && ptr_inc && !acc_done) |=> ptr_addr == $past(ptr_addr) + ADDR_W'(1));
  // R5: with no strobe and no write, the address holds
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !ptr_inc && !acc_done) |=> $stable(ptr_addr));
  // R9: a low-byte write wins over strobes in the same cycle
  p_wr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == RA_W'(PTR_OFS)) |=>
      (ptr_addr[BYTE_W-1:0] == $past(reg_wdata)) &&
      (ptr_addr[ADDR_W-1:BYTE_W] == $past(ptr_addr[ADDR_W-1:BYTE_W])));
endmodule

// File: tb/dptr_pair_ctrl_bench.sv
module dptr_pair_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        acc_done = 1'b0;
  logic        ptr_inc = 1'b0;
  logic [23:0] ptr_addr;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  logic [23:0] m_ptr [2];
  logic [1:0]  m_mode [2];
  logic        m_sel, m_auto;

  always #2 clk = ~clk;

  dptr_pair_ctrl u_dptr_pair_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_done(acc_done),
    .ptr_inc(ptr_inc), .ptr_addr(ptr_addr)
  );

  task automatic chk(string req, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_rdata(logic [2:0] a);
    case (a)
      3'd0: return {1'b0, m_auto, m_mode[1], m_mode[0], 1'b0, m_sel};
      3'd1: return m_ptr[m_sel][7:0];
      3'd2: return m_ptr[m_sel][15:8];
      3'd3: return m_ptr[m_sel][23:16];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [23:0] m_apply(logic [23:0] v, logic [1:0] md);
    case (md)
      2'd1: return v + 24'd1;
      2'd2: return v - 24'd1;
      2'd3: return v ^ 24'd1;
      default: return v;
    endcase
  endfunction

  task automatic m_reset();
    m_ptr[0] = '0; m_ptr[1] = '0;
    m_mode[0] = '0; m_mode[1] = '0;
    m_sel = 1'b0; m_auto = 1'b0;
  endtask

  task automatic m_step();
    if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          m_sel = reg_wdata[0]; m_mode[0] = reg_wdata[3:2];
          m_mode[1] = reg_wdata[5:4]; m_auto = reg_wdata[6];
        end
        3'd1: m_ptr[m_sel][7:0]   = reg_wdata;
        3'd2: m_ptr[m_sel][15:8]  = reg_wdata;
        3'd3: m_ptr[m_sel][23:16] = reg_wdata;
        default: ;
      endcase
    end else begin
      if (ptr_inc) m_ptr[m_sel] = m_ptr[m_sel] + 24'd1;
      if (acc_done) begin
        m_ptr[m_sel] = m_apply(m_ptr[m_sel], m_mode[m_sel]);
        if (m_auto) m_sel = ~m_sel;
      end
    end
  endtask

  task automatic cyc(logic w, logic [2:0] a, logic [7:0] d, logic acc, logic inc);
    @(negedge clk);
    reg_wr = w; reg_addr = a; reg_wdata = d; acc_done = acc; ptr_inc = inc;
    @(posedge clk);
    m_step();
    #1;
    chk(cur_req, "ptr_addr", ptr_addr, m_ptr[m_sel]);
    chk(cur_req, "reg_rdata", {16'h0, reg_rdata}, {16'h0, m_rdata(reg_addr)});
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic rd(logic [2:0] a);
    cyc(1'b0, a, 8'h00, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "ptr_addr", ptr_addr, 24'h0);
    chk("R1", "ctrl", {16'h0, reg_rdata}, 24'h0);

    // R3 / R2: bytes land in the active pointer only
    cur_req = "R3";
    wr(3'd1, 8'h11); wr(3'd2, 8'h22); wr(3'd3, 8'h33);
    chk("R3", "main value", ptr_addr, 24'h332211);
    cur_req = "R2";
    wr(3'd0, 8'h01);
    chk("R2", "shadow active", ptr_addr, 24'h000000);
    wr(3'd1, 8'hAA); wr(3'd3, 8'hCC);
    chk("R2", "shadow value", ptr_addr, 24'hCC00AA);
    wr(3'd0, 8'h00);
    chk("R2", "main kept", ptr_addr, 24'h332211);
    rd(3'd2);
    chk("R3", "read high", {16'h0, reg_rdata}, 24'h22);

    // R4: full-width increment with wrap
    cur_req = "R4";
    wr(3'd1, 8'hFF); wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    chk("R4", "wrap", ptr_addr, 24'h000000);
    wr(3'd1, 8'hFF);
    cyc(1'b0, 3'd0, 8'h00, 1'b0, 1'b1);
    chk("R4", "carry", ptr_addr, 24'h000100);

    // R5 / R10: each mode on main; shadow untouched
    cur_req = "R5";
    wr(3'd0, 8'h04);
    cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0);
    chk("R5", "post-inc", ptr_addr, 24'h000101);
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0);
    chk("R5", "post-dec wrap", ptr_addr, 24'hFFFFFF);
    wr(3'd0, 8'h0C);
    cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0);
    chk("R5", "flip bit0", ptr_addr, 24'hFFFFFE);
    wr(3'd0, 8'h00);
    cyc(1'b0, 3'd1, 8'h00, 1'b1, 1'b0);
    chk("R5", "hold mode", ptr_addr, 24'hFFFFFE);
    cur_req = "R10";
    wr(3'd0, 8'h19);
    rd(3'd0);
    chk("R10", "mode fields", {16'h0, reg_rdata}, 24'h19);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R10", "shadow uses [5:4]", ptr_addr, 24'hCC00AB);

    // R6: auto-swap with distinct modes
    cur_req = "R6";
    wr(3'd0, 8'h64);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R6", "swapped to shadow", ptr_addr, 24'hCC00AB);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R6", "back to main", ptr_addr, 24'hFFFFFF);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b0);
    chk("R6", "shadow after dec", ptr_addr, 24'hCC00AA);

    // R7: spare bits and read-modify-write flip
    cur_req = "R7";
    wr(3'd0, 8'h82);
    rd(3'd0);
    chk("R7", "spare bits read 0", {16'h0, reg_rdata}, 24'h00);
    wr(3'd0, 8'h01 + 8'h01);
    rd(3'd0);
    chk("R7", "bit1 ignored", {16'h0, reg_rdata}, 24'h00);
    wr(3'd0, 8'h05);
    rd(3'd0);
    wr(3'd0, reg_rdata + 8'h01);
    rd(3'd0);
    chk("R7", "rmw+1 clears sel", {16'h0, reg_rdata}, 24'h04);
    wr(3'd5, 8'hFF);
    rd(3'd5);
    chk("R7", "hole reads 0", {16'h0, reg_rdata}, 24'h00);

    // R8: increment and access together
    cur_req = "R8";
    wr(3'd1, 8'h10); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1);
    chk("R8", "inc+postinc", ptr_addr, 24'h000012);
    wr(3'd0, 8'h08);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1);
    chk("R8", "inc+postdec", ptr_addr, 24'h000012);
    wr(3'd0, 8'h4C);
    cyc(1'b0, 3'd0, 8'h00, 1'b1, 1'b1);
    wr(3'd0, 8'h00);
    chk("R8", "inc+flip then swap", ptr_addr, 24'h000012);

    // R9: write drops strobes
    cur_req = "R9";
    wr(3'd0, 8'h44);
    cyc(1'b1, 3'd2, 8'h7E, 1'b1, 1'b1);
    chk("R9", "write wins", ptr_addr, 24'h007E12);
    cyc(1'b1, 3'd0, 8'h44, 1'b1, 1'b0);
    rd(3'd0);
    chk("R9", "no swap on write", {16'h0, reg_rdata}, 24'h44);

    // random overlap of all functions, compared every clock
    cur_req = "R8";
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 4'd0, r[6:4], r[15:8], r[16], r[17]);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule